// File: doc/BRIEF.md
# Framed Serial Packet Receiver

This block sits behind a byte-wide serial receiver and extracts command packets from the raw byte stream. While idle it discards every byte until a start character arrives. It then collects a checksum byte, four header bytes (transmit serial number, response serial number, command identifier and body length) and as many body bytes as the length byte announces. The body bytes go into a small buffer that the consumer reads through an address/data port.

The start character is an ordinary printable value that can also occur inside header or body data. A frame is therefore only trusted when the modulo-256 sum of all bytes after the checksum byte matches that checksum byte. A matching frame raises a one-cycle valid pulse and publishes its header fields. A failing frame raises a one-cycle error pulse and leaves the published header untouched. Bodies longer than the buffer are still counted and summed, but only the first bytes are stored, and a truncation flag accompanies the completion pulse.

Top module: `pkt_frame_rx`

## Requirements
- R1: While hunting, every accepted byte other than 0x21 is discarded: no pulse is raised and the published header fields keep their values.
- R2: After a 0x21 start byte, the next accepted bytes are taken in this order: checksum, transmit serial number, response serial number, command identifier, body length. After a valid packet the header outputs show those four fields.
- R3: A packet whose length byte is 0 completes on that byte, so its pulse is high in the cycle that follows the cycle in which the length byte was valid.
- R4: A packet with length N > 0 completes on its N-th body byte, and idle cycles between bytes are allowed. The pulse is high in the cycle after that byte, and no pulse appears earlier in the frame.
- R5: The expected checksum is the modulo-256 sum of the bytes from the transmit serial number through the last body byte. On a match `pkt_ok` pulses. Otherwise `pkt_bad` pulses, `pkt_ok` stays low and the header outputs are unchanged.
- R6: After `pkt_ok`, body byte i of the packet (i < min(N, 32)) is read at `rd_addr` = i on `rd_data`, with the value available in the same cycle.
- R7: Body bytes past index 31 are not stored, but they still count toward completion and are included in the checksum. `pkt_trunc` is high in the same cycle as the completion pulse exactly when N > 32.
- R8: A 0x21 byte that arrives after the start byte of a frame counts as ordinary data.
- R9: After a packet completes, the receiver is hunting again, so a start byte in the very next cycle opens a new frame.
- R10: After reset all pulses are low and all header outputs are zero.
- R11: `pkt_ok` and `pkt_bad` are never high together, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_byte | input | 8 | Received byte |
| in_valid | input | 1 | `in_byte` is accepted in this cycle |
| pkt_ok | output | 1 | One-cycle pulse: checksum-verified packet complete |
| pkt_bad | output | 1 | One-cycle pulse: completed frame failed its checksum |
| pkt_trunc | output | 1 | With a completion pulse: body exceeded the buffer |
| hdr_txsn | output | 8 | Transmit serial number of the last valid packet |
| hdr_rxsn | output | 8 | Response serial number of the last valid packet |
| hdr_cmd | output | 8 | Command identifier of the last valid packet |
| hdr_len | output | 8 | Body length of the last valid packet |
| rd_addr | input | 5 | Body buffer read address |
| rd_data | output | 8 | Body byte at `rd_addr` |

## Verification
A sequencer that slips by one position shows up at the ports on the very next frame. It either swaps header fields, which the field comparisons catch, or it completes one byte too early or too late, which makes the completion pulse appear in the wrong cycle or not at all. A checksum accumulator that is cleared late or that misses a byte produces a wrong `pkt_bad` on the first frame it touches. A fault in the overflow count corrupts either the stored body or the completion point of frames longer than the buffer. Random frames with gaps, stray start characters and corrupted checksums are mixed with directed length-0, buffer-size and oversize bodies, so each such fault shows up within a few frames.

// File: rtl/pkt_rx_pkg.sv
// Shared types for the framed packet receiver.
package pkt_rx_pkg;
    // Receive sequencer positions, in frame order.
    typedef enum logic [2:0] {
        ST_HUNT, ST_SUM, ST_TXSN, ST_RXSN, ST_CMD, ST_LEN, ST_BODY
    } rx_state_e;

    // Header fields kept for a frame.
    typedef struct packed {
        logic [7:0] txsn;
        logic [7:0] rxsn;
        logic [7:0] cmd;
        logic [7:0] len;
    } pkt_hdr_t;
endpackage

// File: rtl/pkt_rx_sum.sv
// Running modulo-2^W sum of the covered frame bytes.
// Assumes clear and add are never asserted together.
// sum_final is the sum including the byte currently on din.
module pkt_rx_sum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         add,
    input  logic [W-1:0] din,
    output logic [W-1:0] sum_final
);
    logic [W-1:0] acc;

    // Accumulate covered bytes; restart at each start byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc <= '0;
        else if (clear) acc <= '0;
        else if (add)   acc <= acc + din;
    end

    // Sum as it stands once the present byte is included.
    always_comb sum_final = acc + din;
endmodule

// File: rtl/pkt_rx_buf.sv
// Body byte store: one write port, read port with no register stage.
// Assumes the writer keeps waddr inside DEPTH.
module pkt_rx_buf #(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store a body byte.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the addressed byte.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/pkt_rx_seq.sv
// Frame sequencer: hunts for the start byte, steps through the header,
// counts body bytes (also those past the buffer) and decides each frame
// when its last byte arrives, using the checksum from pkt_rx_sum.
// Assumes DEPTH <= 255 and a power of two.
module pkt_rx_seq
    import pkt_rx_pkg::*;
#(
    parameter int         DEPTH = 32,
    parameter logic [7:0] SOF   = 8'h21,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    in_byte,
    input  logic          in_valid,
    input  logic [7:0]    sum_final,
    output logic          sum_clear,
    output logic          sum_add,
    output logic          buf_we,
    output logic [AW-1:0] buf_waddr,
    output logic          pkt_ok,
    output logic          pkt_bad,
    output logic          pkt_trunc,
    output pkt_hdr_t      hdr
);
    localparam logic [7:0] DEPTH_B = 8'(DEPTH);

    rx_state_e  state;
    pkt_hdr_t   cap;
    logic [7:0] exp_sum;
    logic [7:0] body_cnt;
    logic       last_byte;
    logic       sum_match;
    logic [7:0] final_len;

    // Decode the present byte: accumulation, storage and frame end.
    always_comb begin
        sum_clear = in_valid && (state == ST_HUNT) && (in_byte == SOF);
        sum_add   = in_valid && (state inside {ST_TXSN, ST_RXSN, ST_CMD, ST_LEN, ST_BODY});
        buf_we    = in_valid && (state == ST_BODY) && (body_cnt < DEPTH_B);
        buf_waddr = body_cnt[AW-1:0];
        last_byte = in_valid &&
                    (((state == ST_LEN) && (in_byte == 8'd0)) ||
                     ((state == ST_BODY) && ((body_cnt + 8'd1) == cap.len)));
        final_len = (state == ST_LEN) ? in_byte : cap.len;
        sum_match = (sum_final == exp_sum);
    end

    // Step through the frame and capture header bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HUNT;
            cap      <= '0;
            exp_sum  <= '0;
            body_cnt <= '0;
        end else if (in_valid) begin
            case (state)
                ST_HUNT: if (in_byte == SOF) state <= ST_SUM;
                ST_SUM:  begin exp_sum  <= in_byte; state <= ST_TXSN; end
                ST_TXSN: begin cap.txsn <= in_byte; state <= ST_RXSN; end
                ST_RXSN: begin cap.rxsn <= in_byte; state <= ST_CMD;  end
                ST_CMD:  begin cap.cmd  <= in_byte; state <= ST_LEN;  end
                ST_LEN: begin
                    cap.len  <= in_byte;
                    body_cnt <= '0;
                    state    <= (in_byte == 8'd0) ? ST_HUNT : ST_BODY;
                end
                ST_BODY: begin
                    body_cnt <= body_cnt + 8'd1;
                    if (last_byte) state <= ST_HUNT;
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    // Raise the completion pulses one cycle after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_ok    <= 1'b0;
            pkt_bad   <= 1'b0;
            pkt_trunc <= 1'b0;
        end else begin
            pkt_ok    <= last_byte && sum_match;
            pkt_bad   <= last_byte && !sum_match;
            pkt_trunc <= last_byte && (final_len > DEPTH_B);
        end
    end

    // Publish header fields of verified packets only.
    always_ff @(posedge clk) begin
        if (!rst_n)                       hdr <= '0;
        else if (last_byte && sum_match)  hdr <= '{txsn: cap.txsn, rxsn: cap.rxsn,
                                                   cmd: cap.cmd, len: final_len};
    end
endmodule

// File: rtl/pkt_frame_rx.sv
// Top of the framed packet receiver: sequencer, checksum accumulator
// and body buffer. Assumes in_byte is only meaningful while in_valid.
module pkt_frame_rx
    import pkt_rx_pkg::*;
#(
    parameter int         DEPTH = 32,
    parameter logic [7:0] SOF   = 8'h21,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    in_byte,
    input  logic          in_valid,
    output logic          pkt_ok,
    output logic          pkt_bad,
    output logic          pkt_trunc,
    output logic [7:0]    hdr_txsn,
    output logic [7:0]    hdr_rxsn,
    output logic [7:0]    hdr_cmd,
    output logic [7:0]    hdr_len,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic          sum_clear;
    logic          sum_add;
    logic [7:0]    sum_final;
    logic          buf_we;
    logic [AW-1:0] buf_waddr;
    pkt_hdr_t      hdr;

    pkt_rx_seq #(.DEPTH(DEPTH), .SOF(SOF)) u_seq (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
        .sum_final(sum_final), .sum_clear(sum_clear), .sum_add(sum_add),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .pkt_ok(pkt_ok),
        .pkt_bad(pkt_bad), .pkt_trunc(pkt_trunc), .hdr(hdr)
    );

    pkt_rx_sum #(.W(8)) u_sum (
        .clk(clk), .rst_n(rst_n), .clear(sum_clear), .add(sum_add),
        .din(in_byte), .sum_final(sum_final)
    );

    pkt_rx_buf #(.DEPTH(DEPTH), .W(8)) u_buf (
        .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(in_byte),
        .raddr(rd_addr), .rdata(rd_data)
    );

    // Split the published header onto its ports.
    always_comb begin
        hdr_txsn = hdr.txsn;
        hdr_rxsn = hdr.rxsn;
        hdr_cmd  = hdr.cmd;
        hdr_len  = hdr.len;
    end
endmodule

// File: rtl/pkt_rx_chk.sv
// Port-level properties of pkt_frame_rx, bound to every instance.
module pkt_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       pkt_ok,
    input logic       pkt_bad,
    input logic       pkt_trunc,
    input logic [7:0] hdr_txsn,
    input logic [7:0] hdr_rxsn,
    input logic [7:0] hdr_cmd,
    input logic [7:0] hdr_len
);
    // R11
    ok_bad_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_ok && pkt_bad));

    // R11
    ok_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ok |=> !pkt_ok);

    // R11
    bad_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_bad |=> !pkt_bad);

    // R7
    trunc_tied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_trunc |-> (pkt_ok || pkt_bad));

    // R5
    hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_ok |-> $stable({hdr_txsn, hdr_rxsn, hdr_cmd, hdr_len}));

    // R4
    done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_ok || pkt_bad) |-> $past(in_valid));
endmodule

bind pkt_frame_rx pkt_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pkt_ok(pkt_ok),
    .pkt_bad(pkt_bad), .pkt_trunc(pkt_trunc), .hdr_txsn(hdr_txsn),
    .hdr_rxsn(hdr_rxsn), .hdr_cmd(hdr_cmd), .hdr_len(hdr_len)
);

// File: tb/pkt_frame_rx_tb.sv
module pkt_frame_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_valid = 1'b0;
    logic       pkt_ok, pkt_bad, pkt_trunc;
    logic [7:0] hdr_txsn, hdr_rxsn, hdr_cmd, hdr_len;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] bb [256];
    logic [7:0] last_tx = 0, last_rx = 0, last_cmd = 0, last_len = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_frame_rx #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
        .pkt_ok(pkt_ok), .pkt_bad(pkt_bad), .pkt_trunc(pkt_trunc),
        .hdr_txsn(hdr_txsn), .hdr_rxsn(hdr_rxsn), .hdr_cmd(hdr_cmd),
        .hdr_len(hdr_len), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] calc_sum(input logic [7:0] tx, rx, cmd, len);
        logic [7:0] s = tx + rx + cmd + len;
        for (int i = 0; i < len; i++) s = s + bb[i];
        return s;
    endfunction

    task automatic hdr_same(input string tag);
        chk({hdr_txsn, hdr_rxsn, hdr_cmd, hdr_len} == {last_tx, last_rx, last_cmd, last_len},
            tag, {hdr_txsn, hdr_rxsn, hdr_cmd, hdr_len}, {last_tx, last_rx, last_cmd, last_len});
    endtask

    // Drive one byte for a single cycle after an optional idle gap.
    task automatic send_byte(input logic [7:0] b, input int gap);
        repeat (gap) @(negedge clk);
        in_byte  = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'($urandom);
    endtask

    // Send a full frame with body bb[0..len-1] and check its outcome.
    task automatic send_frame(input string tag, input logic [7:0] tx, rx, cmd, len,
                              input bit bad, input int maxgap, input bit drop_chk);
        logic [7:0] seq [262];
        logic [7:0] cs;
        int n, stray, mism, lim;
        cs = calc_sum(tx, rx, cmd, len);
        if (bad) cs = cs + 8'd1 + 8'($urandom % 255);
        seq[0] = 8'h21; seq[1] = cs; seq[2] = tx; seq[3] = rx; seq[4] = cmd; seq[5] = len;
        for (int i = 0; i < len; i++) seq[6+i] = bb[i];
        n = 6 + int'(len);
        stray = 0;
        for (int i = 0; i < n; i++) begin
            send_byte(seq[i], (maxgap > 0) ? int'($urandom % (maxgap + 1)) : 0);
            if (i < n - 1 && (pkt_ok || pkt_bad)) stray++;
        end
        chk(stray == 0, {tag, " R4 early pulse"}, stray, 0);
        chk(pkt_trunc == (len > 8'(DEPTH)), {tag, " R7 trunc flag"}, pkt_trunc, (len > 8'(DEPTH)));
        if (!bad) begin
            chk(pkt_ok && !pkt_bad, {tag, " R4 R5 ok pulse"}, {pkt_ok, pkt_bad}, 2'b10);
            last_tx = tx; last_rx = rx; last_cmd = cmd; last_len = len;
            hdr_same({tag, " R2 header fields"});
            mism = 0;
            lim = (len > 8'(DEPTH)) ? DEPTH : int'(len);
            for (int i = 0; i < lim; i++) begin
                rd_addr = 5'(i);
                #1;
                if (rd_data !== bb[i]) mism++;
            end
            chk(mism == 0, {tag, " R6 R7 body readback"}, mism, 0);
        end else begin
            chk(pkt_bad && !pkt_ok, {tag, " R5 bad pulse"}, {pkt_ok, pkt_bad}, 2'b01);
            hdr_same({tag, " R5 header kept"});
        end
        if (drop_chk) begin
            @(negedge clk);
            chk(!pkt_ok && !pkt_bad, {tag, " R11 single cycle"}, {pkt_ok, pkt_bad}, 0);
        end
    endtask

    task automatic fill_body(input int len, input bit bangs);
        for (int i = 0; i < len; i++) begin
            bb[i] = 8'($urandom);
            if (bangs && ($urandom % 5 == 0)) bb[i] = 8'h21;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int stray;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk({pkt_ok, pkt_bad, pkt_trunc} == 0, "R10 pulses low", {pkt_ok, pkt_bad, pkt_trunc}, 0);
        hdr_same("R10 header zero");

        // R1 junk while hunting
        stray = 0;
        for (int i = 0; i < 20; i++) begin
            logic [7:0] j = 8'($urandom);
            if (j == 8'h21) j = 8'h20;
            send_byte(j, int'($urandom % 2));
            if (pkt_ok || pkt_bad) stray++;
        end
        chk(stray == 0, "R1 junk ignored", stray, 0);
        hdr_same("R1 header untouched");

        // R3 zero-length body
        send_frame("R3", 8'h05, 8'h00, 8'h63, 8'h00, 1'b0, 0, 1'b1);
        fill_body(1, 0);
        send_frame("len1", 8'h06, 8'h51, 8'h64, 8'h01, 1'b0, 2, 1'b1);
        fill_body(32, 0);
        send_frame("len32", 8'h07, 8'h00, 8'h10, 8'd32, 1'b0, 1, 1'b1);
        // R7 oversize bodies
        fill_body(33, 0);
        send_frame("R7 len33", 8'h08, 8'h01, 8'h11, 8'd33, 1'b0, 0, 1'b1);
        fill_body(45, 1);
        send_frame("R7 len45", 8'h09, 8'h02, 8'h12, 8'd45, 1'b0, 1, 1'b1);
        fill_body(40, 0);
        send_frame("R7 bad", 8'h0a, 8'h03, 8'h13, 8'd40, 1'b1, 0, 1'b1);
        // R8 start character inside header and body
        fill_body(6, 0);
        bb[0] = 8'h21; bb[3] = 8'h21;
        send_frame("R8", 8'h21, 8'h21, 8'h21, 8'd6, 1'b0, 0, 1'b1);
        // R5 corrupted checksum
        fill_body(4, 0);
        send_frame("R5", 8'h0b, 8'h00, 8'h20, 8'd4, 1'b1, 1, 1'b1);
        // R9 back-to-back frames
        fill_body(3, 0);
        send_frame("R9 a", 8'h0c, 8'h00, 8'h30, 8'd3, 1'b0, 0, 1'b0);
        send_frame("R9 b", 8'h0d, 8'h0c, 8'h31, 8'd0, 1'b0, 0, 1'b0);
        send_frame("R9 c", 8'h0e, 8'h00, 8'h32, 8'd0, 1'b0, 0, 1'b1);

        // Random frames with idle gaps and junk between them
        for (int k = 0; k < 60; k++) begin
            int len = int'($urandom % 46);
            bit bad = ($urandom % 4 == 0);
            for (int j = 0; j < int'($urandom % 3); j++) begin
                logic [7:0] b = 8'($urandom);
                if (b == 8'h21) b = 8'h7e;
                send_byte(b, 0);
            end
            fill_body(len, 1);
            send_frame("rand", 8'($urandom), 8'($urandom), 8'($urandom), 8'(len), bad, 2, 1'b1);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule